// File: doc/BRIEF.md
# Multichannel Audio Sample FIFO Port

This block is the transmit-side sample buffer of a serial audio port. A processor writes 24-bit samples into it through a four-register bus. A serializer on the far side removes one sample at a time through a pop strobe. All samples share one 256-word store. The number of words that may actually be held depends on how many channels the active format carries, so the usable depth is always a whole number of frames.

The processor sees the fill level in frames, which are words divided by the channel count. It can ask for a request line that stays high while the buffer is at or below half of its frame capacity. Writing into a full buffer and popping from an empty one both raise sticky error flags, and a control command empties the buffer in one cycle.

Register reads are combinational from the address, with no read strobe. A write takes effect at the next rising clock edge. A pop returns the head sample in the same cycle as the strobe.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset the buffer is empty, both error flags are clear, half-level requests are disabled, the format register reads 0, and a single channel is in use.
- R2: A write to the sample register (address 0) stores only bits 23:0 and discards bits 31:24. A 16-bit sample placed left-aligned in bits 23:8 comes back unchanged. Samples leave in write order, and reading address 0 returns 0.
- R3: The format register (address 3) holds a format code in bits 6:4 and a count field in bits 3:0. Codes 0 and 1 use 1 channel, and codes 2 and 3 use 2 channels. Codes 4 and 5 use (bits 3:0)+1 channels, which falls back to 1 channel when that count exceeds 8. Codes 6 and 7 use 1 channel.
- R4: Frame capacity is 256 for 1 channel, 128 for 2 channels, 64 for 3 or 4 channels, and 32 for 5 to 8 channels. The word capacity is the frame capacity times the channel count.
- R5: The status register (address 2) reports floor(words held / channel count) in bits 16:8.
- R6: A sample write made while the words held are at or above the word capacity is dropped and sets the overrun flag, which is status bit 4.
- R7: A pop while the buffer is empty returns 0 and sets the underrun flag, which is status bit 0. A pop from a non-empty buffer returns the oldest sample.
- R8: Both flags stay set until a status write carries that bit at 0. Writing the bit at 1 leaves it set.
- R9: A control write (address 1) with bit 0 set empties the buffer. Bit 0 reads back as 0, and the error flags are not changed.
- R10: Control bit 20 is stored and read back. The output `half_req` is high exactly when bit 20 is set and the frame level is at most half the frame capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 sample, 1 control, 2 status, 3 format |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| smp_pop | input | 1 | Serializer takes one sample |
| smp_data | output | 24 | Head sample, or 0 when empty |
| half_req | output | 1 | Half-level request |

## Verification
The embedded properties assume that `bus_wr`, `bus_addr`, `bus_wdata` and `smp_pop` change only between rising edges. They also assume that a pop and a register write may coincide, but that a clear and a sample write never arrive together, because both use the single write port. The bench respects this by driving every input on the falling edge, one bus operation per cycle. It keeps pops and writes in the same cycle only where it tests simultaneous traffic. It changes the format while samples are held, which can leave the held words above the new capacity. For that reason, the capacity properties are stated on accepted pushes and not on the level.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;

    localparam int ADDR_W       = 2;
    localparam int BUS_W        = 32;
    localparam int FMT_W        = 7;

    localparam logic [ADDR_W-1:0] ADDR_SAMPLE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT   = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_FMT    = 2'd3;

    localparam int CTRL_CLR_BIT  = 0;
    localparam int CTRL_HALF_BIT = 20;
    localparam int STAT_UNR_BIT  = 0;
    localparam int STAT_OVR_BIT  = 4;
    localparam int STAT_LVL_LSB  = 8;

    typedef enum logic [2:0] {
        FMT_MONO     = 3'd0,
        FMT_MONO_DLY = 3'd1,
        FMT_PAIR     = 3'd2,
        FMT_I2S      = 3'd3,
        FMT_SLOT     = 3'd4,
        FMT_SLOT_DLY = 3'd5
    } fmt_code_e;

    typedef struct packed {
        logic             half_en;
        logic             ovr;
        logic             unr;
        logic [FMT_W-1:0] fmt;
    } port_regs_t;

endpackage

// File: rtl/audio_fifo_chan_decode.sv
module audio_fifo_chan_decode #(
    parameter int DEPTH  = 256,
    parameter int MAX_CH = 8,
    parameter int CHW    = 4,
    parameter int CW     = 9
) (
    input  logic [6:0]     fmt,
    output logic [CHW-1:0] chan,
    output logic [CW-1:0]  cap_frames,
    output logic [CW-1:0]  cap_words
);
    import audio_fifo_pkg::*;

    localparam int LOG_MAX = $clog2(MAX_CH);

    logic [4:0] slot_n;
    int         shift;
    int         ch_i;

    always_comb begin
        slot_n = {1'b0, fmt[3:0]} + 5'd1;
        unique case (fmt[6:4])
            FMT_MONO, FMT_MONO_DLY: chan = CHW'(1);
            FMT_PAIR, FMT_I2S:      chan = CHW'(2);
            FMT_SLOT, FMT_SLOT_DLY: begin
                if (int'(slot_n) > MAX_CH) chan = CHW'(1);
                else                       chan = CHW'(slot_n);
            end
            default:                chan = CHW'(1);
        endcase
    end

    // capacity in frames halves each time the channel count passes a power of two
    always_comb begin
        ch_i  = int'(chan);
        shift = 0;
        for (int i = 0; i < LOG_MAX; i++) begin
            if (ch_i > (1 << i)) shift = i + 1;
        end
        cap_frames = CW'(DEPTH >> shift);
        cap_words  = CW'((DEPTH >> shift) * ch_i);
    end

endmodule

// File: rtl/audio_fifo_level.sv
module audio_fifo_level #(
    parameter int CHW = 4,
    parameter int CW  = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  words,
    input  logic [CHW-1:0] chan,
    input  logic [CW-1:0]  cap_frames,
    input  logic           half_en,
    output logic [CW-1:0]  level,
    output logic           half_req
);
    always_comb begin
        level    = words / CW'(chan);
        half_req = half_en && (level <= (cap_frames >> 1));
    end

    // R10: the request is never raised with the enable bit clear
    a_r10_half_gated: assert property (@(posedge clk) disable iff (!rst_n)
        half_req |-> half_en);

    // R10: an empty buffer with requests enabled always requests
    a_r10_empty_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (half_en && words == '0) |-> half_req);

endmodule

// File: rtl/audio_fifo_store.sv
module audio_fifo_store #(
    parameter int DEPTH = 256,
    parameter int SW    = 24,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [SW-1:0] push_data,
    input  logic          pop,
    input  logic          clear,
    output logic [SW-1:0] pop_data,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } store_state_t;

    store_state_t  st_d, st_q;
    logic [SW-1:0] mem_q [DEPTH];
    logic          empty;
    logic          pop_fire;

    always_comb begin
        st_d     = st_q;
        empty    = (st_q.cnt == '0);
        pop_fire = pop && !empty;
        if (clear) begin
            st_d = '0;
        end else begin
            if (push) begin
                st_d.wptr = (st_q.wptr == AW'(DEPTH - 1)) ? '0 : st_q.wptr + AW'(1);
            end
            if (pop_fire) begin
                st_d.rptr = (st_q.rptr == AW'(DEPTH - 1)) ? '0 : st_q.rptr + AW'(1);
            end
            st_d.cnt = st_q.cnt + CW'(push) - CW'(pop_fire);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clear) mem_q[st_q.wptr] <= push_data;
    end

    assign pop_data = empty ? '0 : mem_q[st_q.rptr];
    assign count    = st_q.cnt;

    // R6: the store is never asked to accept a word when physically full
    a_r6_no_push_at_depth: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt < CW'(DEPTH)));

    // R7: an empty pop leaves the word count at zero
    a_r7_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (st_q.cnt == '0));

    // R9: a clear leaves nothing behind
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.cnt == '0));

endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
    parameter int DEPTH    = 256,
    parameter int SAMPLE_W = 24,
    parameter int MAX_CH   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        smp_pop,
    output logic [23:0] smp_data,
    output logic        half_req
);
    import audio_fifo_pkg::*;

    localparam int AW  = $clog2(DEPTH);
    localparam int CW  = AW + 1;
    localparam int CHW = $clog2(MAX_CH + 1);

    port_regs_t           regs_d, regs_q;
    logic [CHW-1:0]       chan;
    logic [CW-1:0]        cap_frames;
    logic [CW-1:0]        cap_words;
    logic [CW-1:0]        words;
    logic [CW-1:0]        level;
    logic                 sample_wr;
    logic                 ctrl_wr;
    logic                 stat_wr;
    logic                 fmt_wr;
    logic                 clr;
    logic                 full;
    logic                 push;
    logic                 pop_empty;
    logic [SAMPLE_W-1:0]  head;

    audio_fifo_chan_decode #(
        .DEPTH (DEPTH),
        .MAX_CH(MAX_CH),
        .CHW   (CHW),
        .CW    (CW)
    ) u_decode (
        .fmt       (regs_q.fmt),
        .chan      (chan),
        .cap_frames(cap_frames),
        .cap_words (cap_words)
    );

    audio_fifo_store #(
        .DEPTH(DEPTH),
        .SW   (SAMPLE_W),
        .AW   (AW),
        .CW   (CW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_data(bus_wdata[SAMPLE_W-1:0]),
        .pop      (smp_pop),
        .clear    (clr),
        .pop_data (head),
        .count    (words)
    );

    audio_fifo_level #(
        .CHW(CHW),
        .CW (CW)
    ) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .words     (words),
        .chan      (chan),
        .cap_frames(cap_frames),
        .half_en   (regs_q.half_en),
        .level     (level),
        .half_req  (half_req)
    );

    always_comb begin
        sample_wr = bus_wr && (bus_addr == ADDR_SAMPLE);
        ctrl_wr   = bus_wr && (bus_addr == ADDR_CTRL);
        stat_wr   = bus_wr && (bus_addr == ADDR_STAT);
        fmt_wr    = bus_wr && (bus_addr == ADDR_FMT);
        clr       = ctrl_wr && bus_wdata[CTRL_CLR_BIT];
        full      = (words >= cap_words);
        push      = sample_wr && !full;
        pop_empty = smp_pop && (words == '0);

        regs_d = regs_q;
        if (ctrl_wr) regs_d.half_en = bus_wdata[CTRL_HALF_BIT];
        if (fmt_wr)  regs_d.fmt     = bus_wdata[FMT_W-1:0];
        if (stat_wr) begin
            regs_d.ovr = regs_q.ovr & bus_wdata[STAT_OVR_BIT];
            regs_d.unr = regs_q.unr & bus_wdata[STAT_UNR_BIT];
        end
        if (sample_wr && full) regs_d.ovr = 1'b1;
        if (pop_empty)         regs_d.unr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata[CTRL_HALF_BIT] = regs_q.half_en;
            ADDR_STAT: begin
                bus_rdata[STAT_LVL_LSB +: CW] = level;
                bus_rdata[STAT_OVR_BIT]       = regs_q.ovr;
                bus_rdata[STAT_UNR_BIT]       = regs_q.unr;
            end
            ADDR_FMT:  bus_rdata[FMT_W-1:0] = regs_q.fmt;
            default:   bus_rdata = '0;
        endcase
    end

    assign smp_data = head;

    // R6: a write into a full buffer is dropped and raises overrun
    a_r6_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_wr && full) |=> (regs_q.ovr && words <= $past(words)));

    // R7: an empty pop returns zero and raises underrun
    a_r7_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pop_empty |-> (smp_data == '0));
    a_r7_empty_pop_flag: assert property (@(posedge clk) disable iff (!rst_n)
        pop_empty |=> regs_q.unr);

    // R8: flags are only lowered by a status write carrying that bit at zero
    a_r8_unr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.unr && !(stat_wr && !bus_wdata[STAT_UNR_BIT])) |=> regs_q.unr);
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ovr && !(stat_wr && !bus_wdata[STAT_OVR_BIT])) |=> regs_q.ovr);

    // R9: a clear leaves both flags untouched
    a_r9_clear_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !smp_pop) |=> (regs_q.ovr == $past(regs_q.ovr) && regs_q.unr == $past(regs_q.unr)));

endmodule

// File: tb/audio_tx_fifo_tb_top.sv
module audio_tx_fifo_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        smp_pop = 1'b0;
    logic [23:0] smp_data;
    logic        half_req;

    always #4 clk = ~clk;

    audio_tx_fifo dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .smp_pop  (smp_pop),
        .smp_data (smp_data),
        .half_req (half_req)
    );

    // behavioural reference state
    int unsigned q[$];
    bit          m_ovr, m_unr, m_half;
    int unsigned m_fmt;
    int          n_checks = 0;
    int          n_fail = 0;
    string       cur_req = "R1";
    bit          done = 0;

    function automatic int m_chan();
        int code = (m_fmt >> 4) & 7;
        int n = (m_fmt & 15) + 1;
        if (code == 2 || code == 3) return 2;
        if (code == 4 || code == 5) return (n > 8) ? 1 : n;
        return 1;
    endfunction

    function automatic int m_capf();
        int c = m_chan();
        if (c == 1) return 256;
        if (c == 2) return 128;
        if (c <= 4) return 64;
        return 32;
    endfunction

    function automatic int m_level();
        return q.size() / m_chan();
    endfunction

    function automatic logic [31:0] m_rdata(input logic [1:0] a);
        case (a)
            2'd1: return 32'(m_half) << 20;
            2'd2: return (32'(m_level()) << 8) | (32'(m_ovr) << 4) | 32'(m_unr);
            2'd3: return 32'(m_fmt);
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, compare combinational outputs, update model at rising edge
    task automatic step(input bit wr, input logic [1:0] a, input logic [31:0] d, input bit pop);
        bit full;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; smp_pop = pop;
        #1;
        check(cur_req, "rdata", bus_rdata, m_rdata(a));
        check(cur_req, "smp_data", 32'(smp_data), (pop && q.size() > 0) ? 32'(q[0]) : (q.size() > 0 ? 32'(q[0]) : 32'd0));
        check(cur_req, "half_req", 32'(half_req),
              32'(m_half && (m_level() <= m_capf() / 2)));
        @(posedge clk);
        full = (q.size() >= m_capf() * m_chan());
        if (pop) begin
            if (q.size() > 0) void'(q.pop_front());
            else m_unr = 1;
        end
        if (wr) begin
            case (a)
                2'd0: if (full) m_ovr = 1; else q.push_back(d & 32'h00FF_FFFF);
                2'd1: begin m_half = d[20]; if (d[0]) q.delete(); end
                2'd2: begin m_ovr = m_ovr & d[4]; m_unr = (m_unr & d[0]) | (pop && m_unr); end
                default: m_fmt = d[6:0];
            endcase
        end
    endtask

    task automatic rd(input logic [1:0] a);
        step(0, a, 0, 0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        step(1, a, d, 0);
    endtask

    task automatic pop1();
        step(0, 2'd2, 0, 1);
    endtask

    task automatic fill(input int n, input int base);
        for (int i = 0; i < n; i++) wr(2'd0, 32'(base + i));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        q.delete(); m_ovr = 0; m_unr = 0; m_half = 0; m_fmt = 0;

        // R1: reset values on every register
        cur_req = "R1";
        for (int a = 0; a < 4; a++) rd(2'(a));

        // R2: bit truncation, left-aligned 16-bit sample, order, sample reg reads 0
        cur_req = "R2";
        wr(2'd0, 32'hAB12_3456);
        wr(2'd0, 32'h00BE_EF00);
        wr(2'd0, 32'h0000_0001);
        rd(2'd0);
        cur_req = "R5";
        rd(2'd2);
        cur_req = "R2";
        pop1(); pop1(); pop1();

        // R7: empty pop gives zero and underrun
        cur_req = "R7";
        pop1();
        rd(2'd2);

        // R8: writing 1 keeps the flag, writing 0 lowers it
        cur_req = "R8";
        wr(2'd2, 32'h0000_0011);
        rd(2'd2);
        wr(2'd2, 32'h0000_0000);
        rd(2'd2);

        // R10: enable half request, then fill mono buffer past half
        cur_req = "R10";
        wr(2'd1, 32'h0010_0000);
        rd(2'd1);
        fill(130, 32'h100);
        rd(2'd2);

        // R6: fill to 256 words, extra write dropped with overrun
        cur_req = "R6";
        fill(126, 32'h200);
        rd(2'd2);
        wr(2'd0, 32'h00FF_FFFF);
        rd(2'd2);
        step(1, 2'd0, 32'h0012_3456, 1);   // write while full with concurrent pop
        rd(2'd2);

        // R9: clear empties, keeps flags and half enable; bit 0 reads 0
        cur_req = "R9";
        wr(2'd1, 32'h0010_0001);
        rd(2'd1);
        rd(2'd2);
        pop1();
        wr(2'd2, 32'h0);
        rd(2'd2);

        // R3 / R4 / R5: two-channel format
        cur_req = "R4";
        wr(2'd3, 32'h0000_0020);
        rd(2'd3);
        cur_req = "R5";
        fill(3, 32'h300);
        rd(2'd2);
        wr(2'd1, 32'h0010_0001);

        // R3: slot format with three channels, capacity 64 frames = 192 words
        cur_req = "R3";
        wr(2'd3, 32'h0000_0042);
        fill(192, 32'h400);
        rd(2'd2);
        wr(2'd0, 32'h0000_0777);
        rd(2'd2);
        wr(2'd1, 32'h0000_0001);
        wr(2'd2, 32'h0);

        // R4: six channels, 32 frames = 192 words
        cur_req = "R4";
        wr(2'd3, 32'h0000_0055);
        wr(2'd1, 32'h0010_0000);
        fill(97, 32'h500);
        rd(2'd2);
        fill(95, 32'h600);
        wr(2'd0, 32'h0000_0888);
        rd(2'd2);
        wr(2'd1, 32'h0010_0001);
        wr(2'd2, 32'h0);

        // R3: illegal slot count (10) and unused code 6 fall back to one channel
        cur_req = "R3";
        wr(2'd3, 32'h0000_0049);
        fill(5, 32'h700);
        rd(2'd2);
        wr(2'd3, 32'h0000_0063);
        rd(2'd2);
        wr(2'd3, 32'h0000_0047);     // eight channels, legal
        rd(2'd2);
        for (int i = 0; i < 6; i++) pop1();
        rd(2'd2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule